// File: doc/BRIEF.md
# Legacy I/O Controller Configuration Port

This block is the configuration front end of a legacy I/O controller. Software reaches it through two adjacent byte locations on a simple bus. The lower location selects a register and the upper one moves data to or from that register. Until software writes an unlock key twice in a row, configuration access stays closed. In that state data writes are dropped and data reads return all ones. One further key value closes access again.

When access is open, the block holds a handful of global registers. One is a logical-device number. Others control the floppy-controller enable, the I2C pin sharing and a two-bit pin-function select. Two registers report a fixed chip identifier. Register indices 0x30 and above are not stored here. An access to one of them becomes a one-cycle read or write strobe. The strobe carries the register index, the write byte and the selected device number out to the attached function. On a read, the byte that function returns is passed back to the bus.

Top module: `sio_cfg_port`

## Requirements
- R1: A write with `bus_addr`=0 while unlocked loads the index register. Exception: the byte 0xAA. A read with `bus_addr`=0 while unlocked returns the current index.
- R2: The block leaves the locked state only after two consecutive index-port writes of 0x87. Any other byte written to the index port in between restarts the count.
- R3: While unlocked, an index-port write of 0xAA returns the block to the locked state. The index register is left unchanged.
- R4: While locked, data-port writes change no register and raise no strobe. Reads of either port return 0xFF.
- R5: Index 0x07 is the logical-device number. It can be read and written, and `dev_num` shows it.
- R6: Index 0x20 reads 0xA2. Index 0x21 reads {4'h3, REVISION}. Both are read-only.
- R7: Index 0x2C can be read and written. Its bits 1:0 drive `cfg_pin_func`, encoded as 0 = IR off, 1 = IR, 2 = GPIO1, 3 = UART B.
- R8: Index 0x24 bit 1 drives `cfg_fdc_en`. Index 0x2A bit 1 drives `cfg_i2c_sel`. Both registers can be read and written in full.
- R9: An unlocked data-port write to an index of 0x30 or above pulses `dev_wr_stb` in the same cycle. During that cycle `dev_reg` equals the index and `dev_wdata` equals the bus byte. Below 0x30 no write strobe is raised.
- R10: An unlocked data-port read at an index of 0x30 or above pulses `dev_rd_stb` and returns `dev_rdata`.
- R11: Global indices below 0x30 that are not listed in R5 to R8 read 0x00, and writes to them have no effect.
- R12: After reset the block is locked with index 0x00 and device 0x00. Register 0x24 holds OPT_RESET (0x02), 0x2A holds I2C_RESET (0x00) and 0x2C holds PINSEL_RESET (0x02).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write |
| bus_rd | input | 1 | Byte read |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| dev_num | output | 8 | Selected logical device |
| dev_reg | output | 8 | Register index for banked access |
| dev_wdata | output | 8 | Write byte for banked access |
| dev_wr_stb | output | 1 | Banked register write strobe |
| dev_rd_stb | output | 1 | Banked register read strobe |
| dev_rdata | input | 8 | Read byte from the attached function |
| cfg_fdc_en | output | 1 | Floppy controller enable |
| cfg_i2c_sel | output | 1 | Shared pins used as I2C |
| cfg_pin_func | output | 2 | Pin function select |

## Verification
The assertions assume that a cycle never carries both a read and a write. They also assume that `bus_wdata` is meaningful only while `bus_wr` is high. The stimulus issues exactly one operation per cycle and never overlaps the two. It drives every input away from the sampling edge, so the combinational read path and the strobes are seen in the same cycle as the request.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter logic [3:0] REVISION     = 4'h1,
  parameter logic [7:0] OPT_RESET    = 8'h02,
  parameter logic [7:0] I2C_RESET    = 8'h00,
  parameter logic [7:0] PINSEL_RESET = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [7:0] dev_num,
  output logic [7:0] dev_reg,
  output logic [7:0] dev_wdata,
  output logic       dev_wr_stb,
  output logic       dev_rd_stb,
  input  logic [7:0] dev_rdata,
  output logic       cfg_fdc_en,
  output logic       cfg_i2c_sel,
  output logic [1:0] cfg_pin_func
);
  localparam logic [7:0] KEY_OPEN  = 8'h87;
  localparam logic [7:0] KEY_CLOSE = 8'hAA;
  localparam logic [7:0] IX_LDN    = 8'h07;
  localparam logic [7:0] IX_ID_HI  = 8'h20;
  localparam logic [7:0] IX_ID_LO  = 8'h21;
  localparam logic [7:0] IX_OPT    = 8'h24;
  localparam logic [7:0] IX_I2C    = 8'h2A;
  localparam logic [7:0] IX_PINSEL = 8'h2C;
  localparam logic [7:0] IX_BANK   = 8'h30;
  localparam logic [7:0] ID_HI     = 8'hA2;
  localparam logic [7:0] ID_LO     = {4'h3, REVISION};

  logic       locked, key_half;
  logic [7:0] index_q, ldn_q, opt_q, i2c_q, pinsel_q;

  wire idx_wr = bus_wr & ~bus_addr;
  wire dat_wr = bus_wr &  bus_addr;
  wire dat_rd = bus_rd &  bus_addr;
  wire banked = index_q >= IX_BANK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b1;
      key_half <= 1'b0;
      index_q  <= 8'h00;
      ldn_q    <= 8'h00;
      opt_q    <= OPT_RESET;
      i2c_q    <= I2C_RESET;
      pinsel_q <= PINSEL_RESET;
    end else if (locked) begin
      if (idx_wr) begin
        if (bus_wdata == KEY_OPEN) begin
          key_half <= ~key_half;
          if (key_half) locked <= 1'b0;
        end else begin
          key_half <= 1'b0;
        end
      end
    end else begin
      if (idx_wr) begin
        if (bus_wdata == KEY_CLOSE) locked  <= 1'b1;
        else                        index_q <= bus_wdata;
      end
      if (dat_wr) begin
        case (index_q)
          IX_LDN:    ldn_q    <= bus_wdata;
          IX_OPT:    opt_q    <= bus_wdata;
          IX_I2C:    i2c_q    <= bus_wdata;
          IX_PINSEL: pinsel_q <= bus_wdata;
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    if (locked)        bus_rdata = 8'hFF;
    else if (!bus_addr) bus_rdata = index_q;
    else if (banked)   bus_rdata = dev_rdata;
    else begin
      case (index_q)
        IX_LDN:    bus_rdata = ldn_q;
        IX_ID_HI:  bus_rdata = ID_HI;
        IX_ID_LO:  bus_rdata = ID_LO;
        IX_OPT:    bus_rdata = opt_q;
        IX_I2C:    bus_rdata = i2c_q;
        IX_PINSEL: bus_rdata = pinsel_q;
        default:   bus_rdata = 8'h00;
      endcase
    end
  end

  assign dev_wr_stb   = dat_wr & ~locked & banked;
  assign dev_rd_stb   = dat_rd & ~locked & banked;
  assign dev_reg      = index_q;
  assign dev_wdata    = bus_wdata;
  assign dev_num      = ldn_q;
  assign cfg_fdc_en   = opt_q[1];
  assign cfg_i2c_sel  = i2c_q[1];
  assign cfg_pin_func = pinsel_q[1:0];
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] dev_num,
  input logic [7:0] dev_reg,
  input logic       dev_wr_stb,
  input logic       locked
);
  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && $past(locked)) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87));

  p_close_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> locked);

  p_locked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_rd) |-> bus_rdata == 8'hFF);

  p_locked_nostb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !dev_wr_stb);

  p_ldn_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr && dev_reg == 8'h07) |=> $stable(dev_num));

  p_id_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && bus_rd && bus_addr && dev_reg == 8'h20) |-> bus_rdata == 8'hA2);

  p_bank_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr_stb |-> (bus_wr && bus_addr && dev_reg >= 8'h30));
endmodule

bind sio_cfg_port sio_cfg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .dev_num(dev_num), .dev_reg(dev_reg), .dev_wr_stb(dev_wr_stb),
  .locked(locked)
);

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00, dev_rdata = 8'h3C;
  logic [7:0] bus_rdata, dev_num, dev_reg, dev_wdata;
  logic dev_wr_stb, dev_rd_stb, cfg_fdc_en, cfg_i2c_sel;
  logic [1:0] cfg_pin_func;

  always #5 clk = ~clk;

  sio_cfg_port i_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_num(dev_num), .dev_reg(dev_reg), .dev_wdata(dev_wdata),
    .dev_wr_stb(dev_wr_stb), .dev_rd_stb(dev_rd_stb), .dev_rdata(dev_rdata),
    .cfg_fdc_en(cfg_fdc_en), .cfg_i2c_sel(cfg_i2c_sel), .cfg_pin_func(cfg_pin_func)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit m_locked;
  int m_keys;
  int m_idx, m_ldn, m_opt, m_i2c, m_pin;

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_read(bit a);
    if (m_locked) return 8'hFF;
    if (!a) return m_idx;
    if (m_idx >= 8'h30) return int'(dev_rdata);
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'hA2;
      8'h21: return 8'h31;
      8'h24: return m_opt;
      8'h2A: return m_i2c;
      8'h2C: return m_pin;
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_locked = 1; m_keys = 0; m_idx = 0; m_ldn = 0;
    m_opt = 8'h02; m_i2c = 8'h00; m_pin = 8'h02;
  endtask

  task automatic op(string tag, bit wr, bit rd, bit a, int d);
    bit bank_wr, bank_rd;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d[7:0];
    #1;
    bank_wr = wr && a && !m_locked && m_idx >= 8'h30;
    bank_rd = rd && a && !m_locked && m_idx >= 8'h30;
    if (rd) chk(tag, int'(bus_rdata), exp_read(a));
    chk("R9 write strobe", int'(dev_wr_stb), int'(bank_wr));
    chk("R10 read strobe", int'(dev_rd_stb), int'(bank_rd));
    if (bank_wr) begin
      chk("R9 strobe index", int'(dev_reg), m_idx);
      chk("R9 strobe data", int'(dev_wdata), d);
    end
    chk("R5 device number", int'(dev_num), m_ldn);
    chk("R7 pin function", int'(cfg_pin_func), m_pin % 4);
    chk("R8 fdc enable", int'(cfg_fdc_en), (m_opt >> 1) % 2);
    chk("R8 i2c select", int'(cfg_i2c_sel), (m_i2c >> 1) % 2);
    if (m_locked) begin
      if (wr && !a) begin
        if (d == 8'h87) begin
          m_keys++;
          if (m_keys == 2) begin m_locked = 0; m_keys = 0; end
        end else m_keys = 0;
      end
    end else begin
      if (wr && !a) begin
        if (d == 8'hAA) m_locked = 1; else m_idx = d;
      end
      if (wr && a) begin
        case (m_idx)
          8'h07: m_ldn = d;
          8'h24: m_opt = d;
          8'h2A: m_i2c = d;
          8'h2C: m_pin = d;
          default: ;
        endcase
      end
    end
  endtask

  task automatic wi(string t, int d); op(t, 1, 0, 0, d); endtask
  task automatic wd(string t, int d); op(t, 1, 0, 1, d); endtask
  task automatic rd_d(string t);      op(t, 0, 1, 1, 0); endtask
  task automatic rd_i(string t);      op(t, 0, 1, 0, 0); endtask

  initial begin
    #2000000;
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    rd_d("R12 reset locked read");
    rd_i("R12 reset index read");
    wi("R4 locked index write", 8'h2C);
    wd("R4 locked data write", 8'h03);
    rd_d("R4 locked data read");
    wi("R2 first key", 8'h87);
    wi("R2 break byte", 8'h55);
    wi("R2 single key after break", 8'h87);
    rd_d("R2 still locked");
    wi("R2 second key", 8'h87);
    rd_i("R12 index after unlock");
    rd_d("R12 default index 0 read");
    wi("R1 load index", 8'h20); rd_i("R1 index readback");
    rd_d("R6 id high");
    wi("R6 select id low", 8'h21); rd_d("R6 id low");
    wd("R6 id low write", 8'h00); rd_d("R6 id read-only");
    wi("R5 select ldn", 8'h07); wd("R5 write ldn", 8'h09); rd_d("R5 ldn readback");
    wi("R7 select pinsel", 8'h2C);
    for (int v = 0; v < 4; v++) begin
      wd("R7 write pinsel", 8'hC0 | v); rd_d("R7 pinsel readback");
    end
    wi("R8 select opt", 8'h24); wd("R8 clear fdc", 8'h00); rd_d("R8 opt readback");
    wd("R8 set fdc", 8'hFE); rd_d("R8 opt readback 2");
    wi("R8 select i2c", 8'h2A); wd("R8 set i2c", 8'h02); rd_d("R8 i2c readback");
    wi("R9 select bank", 8'h30); wd("R9 bank write", 8'h5E);
    wi("R11 select 2F", 8'h2F); wd("R11 unimpl write", 8'h77); rd_d("R11 unimpl read");
    wi("R11 select 22", 8'h22); wd("R11 unimpl write 22", 8'hFF); rd_d("R11 unimpl read 22");
    dev_rdata = 8'hA5;
    wi("R10 select E1", 8'hE1); rd_d("R10 bank read"); wd("R9 bank write E1", 8'h11);
    dev_rdata = 8'h4B;
    for (int i = 0; i < 256; i++) begin
      if (i != 8'hAA) begin wi("R1 sweep index", i); rd_d("R11 sweep read"); end
    end
    wi("R1 select ldn", 8'h07);
    wi("R3 exit key", 8'hAA);
    rd_d("R3 locked after exit"); rd_i("R3 locked index read");
    wd("R4 locked ldn write", 8'h44);
    wi("R2 reopen a", 8'h87); wi("R2 reopen b", 8'h87);
    rd_i("R3 index kept"); rd_d("R4 ldn untouched");
    wi("R1 index 87 when open", 8'h87); rd_i("R1 index 87 readback");
    op("R12 idle", 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule